// File: doc/BRIEF.md
# Sixteen-Operation ALU with Flag Update

This block is the integer data-processing stage of a processor datapath. It receives operand A, an operand B that has already passed through the shifter together with the carry the shifter produced, a 4-bit operation code, a set-flags control, the current condition flags and a marker saying whether the destination register is the program counter. One clock later it presents the result, a write enable for the destination, the next value of the four condition flags and a request to restore the saved status word.

The sixteen operations fall into logical ones, which take their carry from the shifter and never touch overflow, and arithmetic ones, which share a single adder that can swap its inputs, invert the second one and take a carry-in of zero, one or the current carry flag. Test and compare operations set the flags but write no result. A flag-setting operation that writes the program counter does not compute flags at all; it asks the surrounding logic to reload the status word from its saved copy.

The flags bus is packed as N in bit 3, Z in bit 2, C in bit 1 and V in bit 0, on both the input and the output.

Top module: `dp_alu`

## Requirements
- R1: With issue high, the registered result equals the operation selected by the code: 0 A and B, 1 A xor B, 2 A minus B, 3 B minus A, 4 A plus B, 5 A plus B plus C, 6 A minus B minus (not C), 7 B minus A minus (not C), 8 A and B, 9 A xor B, 10 A minus B, 11 A plus B, 12 A or B, 13 B, 14 A and not B, 15 not B (all modulo 2^32, C being flag input bit 1).
- R2: Codes 8 to 11 never raise the write enable and update the flags whether or not set-flags is high; every other code raises the write enable one cycle after it is issued.
- R3: Arithmetic codes (2 to 7, 10, 11) set C to the carry out of the unsigned 33-bit sum; for the subtracting forms C is 1 exactly when no borrow occurs.
- R4: Arithmetic codes set V when the signed result does not fit in 32 bits; logical codes take C from the shifter carry input and leave V at its input value.
- R5: Whenever flags are updated, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R6: For a writing code with set-flags and the program-counter marker both high, the restore request rises one cycle later and the flags output equals the flags input unchanged.
- R7: For a writing code with set-flags low, the flags output equals the flags input unchanged.
- R8: All outputs are registered with one cycle of latency and are zero during reset; in a cycle with issue low the write enable and restore request are low, the flags output copies the flags input and the result holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An operation is presented this cycle |
| opcode_i | input | 4 | Operation code |
| opnd_a_i | input | WIDTH | First operand |
| opnd_b_i | input | WIDTH | Second operand, already shifted |
| shift_carry_i | input | 1 | Carry produced by the shifter |
| set_flags_i | input | 1 | Request a flag update |
| dest_pc_i | input | 1 | Destination is the program counter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | WIDTH | Registered result |
| wr_en_o | output | 1 | Write the result to the destination |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| restore_req_o | output | 1 | Copy saved status word into current status |

## Verification
Every output of an operation issued before a rising edge is due right after that edge, so the bench drives stimulus on the falling edge, computes the expected values at once from its own 64-bit signed and unsigned arithmetic, and compares on the next falling edge before it drives the following operation. Idle cycles are mixed in so the hold and pass-through behaviour is checked in the same one-cycle window. Boundary operands 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF are crossed with every code, both carry-in values and both set-flags settings, followed by random traffic.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND       = 4'd0,
        OP_XOR       = 4'd1,
        OP_SUB_AB    = 4'd2,
        OP_SUB_BA    = 4'd3,
        OP_ADD       = 4'd4,
        OP_ADD_C     = 4'd5,
        OP_SUB_AB_C  = 4'd6,
        OP_SUB_BA_C  = 4'd7,
        OP_TEST_AND  = 4'd8,
        OP_TEST_XOR  = 4'd9,
        OP_CMP_SUB   = 4'd10,
        OP_CMP_ADD   = 4'd11,
        OP_OR        = 4'd12,
        OP_PASS_B    = 4'd13,
        OP_CLEAR_B   = 4'd14,
        OP_PASS_NOTB = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic     is_arith;
        logic     writes;
        logic     swap;
        logic     invert;
        cin_sel_e cin_sel;
    } op_ctrl_t;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
    localparam int FLAG_W = 4;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [3:0] opcode_i,
    output op_ctrl_t   ctrl_o
);

    alu_op_e op;
    assign op = alu_op_e'(opcode_i);

    always_comb begin
        ctrl_o = '{is_arith: 1'b0, writes: 1'b1, swap: 1'b0,
                   invert: 1'b0, cin_sel: CIN_ZERO};
        unique case (op)
            OP_AND, OP_XOR, OP_OR, OP_PASS_B, OP_CLEAR_B, OP_PASS_NOTB: begin
                ctrl_o.writes = 1'b1;
            end
            OP_TEST_AND, OP_TEST_XOR: begin
                ctrl_o.writes = 1'b0;
            end
            OP_SUB_AB: begin
                ctrl_o.is_arith = 1'b1;
                ctrl_o.invert   = 1'b1;
                ctrl_o.cin_sel  = CIN_ONE;
            end
            OP_SUB_BA: begin
                ctrl_o.is_arith = 1'b1;
                ctrl_o.swap     = 1'b1;
                ctrl_o.invert   = 1'b1;
                ctrl_o.cin_sel  = CIN_ONE;
            end
            OP_ADD: begin
                ctrl_o.is_arith = 1'b1;
            end
            OP_ADD_C: begin
                ctrl_o.is_arith = 1'b1;
                ctrl_o.cin_sel  = CIN_FLAG;
            end
            OP_SUB_AB_C: begin
                ctrl_o.is_arith = 1'b1;
                ctrl_o.invert   = 1'b1;
                ctrl_o.cin_sel  = CIN_FLAG;
            end
            OP_SUB_BA_C: begin
                ctrl_o.is_arith = 1'b1;
                ctrl_o.swap     = 1'b1;
                ctrl_o.invert   = 1'b1;
                ctrl_o.cin_sel  = CIN_FLAG;
            end
            OP_CMP_SUB: begin
                ctrl_o.is_arith = 1'b1;
                ctrl_o.writes   = 1'b0;
                ctrl_o.invert   = 1'b1;
                ctrl_o.cin_sel  = CIN_ONE;
            end
            OP_CMP_ADD: begin
                ctrl_o.is_arith = 1'b1;
                ctrl_o.writes   = 1'b0;
            end
            default: begin
                ctrl_o.writes = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             swap_i,
    input  logic             invert_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] lhs, rhs_raw, rhs;
    logic [WIDTH:0]   wide;

    always_comb begin
        lhs     = swap_i ? b_i : a_i;
        rhs_raw = swap_i ? a_i : b_i;
        rhs     = invert_i ? ~rhs_raw : rhs_raw;
        wide    = {1'b0, lhs} + {1'b0, rhs} + {{WIDTH{1'b0}}, cin_i};
        sum_o   = wide[MSB:0];
        carry_o = wide[WIDTH];
        ovf_o   = (lhs[MSB] == rhs[MSB]) && (wide[MSB] != lhs[MSB]);
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       opcode_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);

    always_comb begin
        unique case (alu_op_e'(opcode_i))
            OP_AND, OP_TEST_AND: res_o = a_i & b_i;
            OP_XOR, OP_TEST_XOR: res_o = a_i ^ b_i;
            OP_OR:               res_o = a_i | b_i;
            OP_PASS_B:           res_o = b_i;
            OP_CLEAR_B:          res_o = a_i & ~b_i;
            OP_PASS_NOTB:        res_o = ~b_i;
            default:             res_o = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_i,
    input  logic [3:0]          opcode_i,
    input  logic [WIDTH-1:0]    opnd_a_i,
    input  logic [WIDTH-1:0]    opnd_b_i,
    input  logic                shift_carry_i,
    input  logic                set_flags_i,
    input  logic                dest_pc_i,
    input  logic [FLAG_W-1:0]   flags_i,
    output logic [WIDTH-1:0]    result_o,
    output logic                wr_en_o,
    output logic [FLAG_W-1:0]   flags_o,
    output logic                restore_req_o
);

    localparam int MSB = WIDTH - 1;

    op_ctrl_t          ctrl;
    logic [WIDTH-1:0]  arith_res, logic_res, res_d;
    logic              arith_c, arith_v, cin;
    logic              do_restore, do_update;
    logic [FLAG_W-1:0] flags_d;

    alu_op_decode u_dec (
        .opcode_i (opcode_i),
        .ctrl_o   (ctrl)
    );

    always_comb begin
        unique case (ctrl.cin_sel)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = flags_i[FLAG_C];
            default:  cin = 1'b0;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_add (
        .a_i      (opnd_a_i),
        .b_i      (opnd_b_i),
        .swap_i   (ctrl.swap),
        .invert_i (ctrl.invert),
        .cin_i    (cin),
        .sum_o    (arith_res),
        .carry_o  (arith_c),
        .ovf_o    (arith_v)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_log (
        .opcode_i (opcode_i),
        .a_i      (opnd_a_i),
        .b_i      (opnd_b_i),
        .res_o    (logic_res)
    );

    always_comb begin
        res_d      = ctrl.is_arith ? arith_res : logic_res;
        do_restore = issue_i && ctrl.writes && set_flags_i && dest_pc_i;
        do_update  = issue_i && !do_restore && (set_flags_i || !ctrl.writes);
        flags_d    = flags_i;
        if (do_update) begin
            flags_d[FLAG_N] = res_d[MSB];
            flags_d[FLAG_Z] = (res_d == '0);
            flags_d[FLAG_C] = ctrl.is_arith ? arith_c : shift_carry_i;
            flags_d[FLAG_V] = ctrl.is_arith ? arith_v : flags_i[FLAG_V];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o      <= '0;
            wr_en_o       <= 1'b0;
            flags_o       <= '0;
            restore_req_o <= 1'b0;
        end else begin
            if (issue_i) result_o <= res_d;
            wr_en_o       <= issue_i && ctrl.writes;
            flags_o       <= flags_d;
            restore_req_o <= do_restore;
        end
    end

    // R2
    no_cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i[3:2] == 2'b10) |=> !wr_en_o);

    // R3
    cmp_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == 4'd10 && opnd_a_i == opnd_b_i)
        |=> (flags_o[FLAG_Z] && flags_o[FLAG_C]));

    // R4
    logic_v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (opcode_i < 4'd2 || opcode_i > 4'd11 || opcode_i == 4'd8 || opcode_i == 4'd9))
        |=> (flags_o[FLAG_V] == $past(flags_i[FLAG_V])));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && set_flags_i && !dest_pc_i)
        |=> (flags_o[FLAG_Z] == (result_o == '0)));

    // R6
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && set_flags_i && dest_pc_i && opcode_i[3:2] != 2'b10)
        |=> (restore_req_o && flags_o == $past(flags_i)));

    // R7
    no_set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !set_flags_i && opcode_i[3:2] != 2'b10)
        |=> (flags_o == $past(flags_i)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!wr_en_o && !restore_req_o && $stable(result_o)));

endmodule

// File: tb/dp_alu_test.sv
module dp_alu_test;
    localparam int W = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n, issue, shc, sf, dpc;
    logic [3:0]   op, fl_in;
    logic [W-1:0] a, b;
    logic [W-1:0] result;
    logic         wr_en, restore;
    logic [3:0]   fl_out;

    dp_alu #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .opcode_i(op),
        .opnd_a_i(a), .opnd_b_i(b), .shift_carry_i(shc),
        .set_flags_i(sf), .dest_pc_i(dpc), .flags_i(fl_in),
        .result_o(result), .wr_en_o(wr_en), .flags_o(fl_out),
        .restore_req_o(restore)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    logic [W-1:0] exp_res = '0;
    logic         exp_we, exp_rq, exp_upd, pending = 0;
    logic [3:0]   exp_fl;
    string        fl_tag;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic model();
        longint ux, uy, full, sx, sy, sv;
        logic [W-1:0] r;
        logic c, v, arith, writes, add, cf;
        int bor;
        cf = fl_in[1];
        arith = 1; add = 0; bor = 0; ux = 0; uy = 0;
        r = '0; c = 0; v = 0;
        writes = !(op >= 4'd8 && op <= 4'd11);
        case (op)
            4'd0, 4'd8: begin r = a & b; arith = 0; end
            4'd1, 4'd9: begin r = a ^ b; arith = 0; end
            4'd12: begin r = a | b; arith = 0; end
            4'd13: begin r = b; arith = 0; end
            4'd14: begin r = a & ~b; arith = 0; end
            4'd15: begin r = ~b; arith = 0; end
            4'd2, 4'd10: begin ux = a; uy = b; end
            4'd3: begin ux = b; uy = a; end
            4'd6: begin ux = a; uy = b; bor = cf ? 0 : 1; end
            4'd7: begin ux = b; uy = a; bor = cf ? 0 : 1; end
            4'd4, 4'd11: begin ux = a; uy = b; add = 1; end
            4'd5: begin ux = a; uy = b; add = 1; bor = cf ? 1 : 0; end
            default: ;
        endcase
        if (arith) begin
            sx = longint'($signed(ux[31:0]));
            sy = longint'($signed(uy[31:0]));
            if (add) begin
                full = ux + uy + bor;
                c = full > 64'hFFFF_FFFF;
                sv = sx + sy + bor;
            end else begin
                full = ux - uy - bor;
                c = ux >= uy + bor;
                sv = sx - sy - bor;
            end
            r = full[31:0];
            v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        end
        exp_we  = issue && writes;
        exp_rq  = issue && writes && sf && dpc;
        exp_upd = issue && !exp_rq && (sf || !writes);
        exp_fl  = fl_in;
        if (issue) exp_res = r;
        if (exp_upd) exp_fl = {r[31], r == 0, arith ? c : shc, arith ? v : fl_in[0]};
        if (!issue)            fl_tag = "R8 idle flags";
        else if (exp_rq)       fl_tag = "R6 restore flags";
        else if (!exp_upd)     fl_tag = "R7 hold flags";
        else if (arith)        fl_tag = "R3 R4 arith flags";
        else                   fl_tag = "R4 logic flags";
    endtask

    task automatic compare();
        chk("R1 result", result, exp_res);
        chk(exp_we ? "R2 wr_en" : "R2 R8 wr_en low", wr_en, exp_we);
        chk("R6 restore", restore, exp_rq);
        chk(fl_tag, fl_out, exp_fl);
        if (exp_upd) chk("R5 N/Z", fl_out[3:2], exp_fl[3:2]);
    endtask

    task automatic apply(input logic i, input logic [3:0] o, input logic [W-1:0] va,
                         input logic [W-1:0] vb, input logic s, input logic f,
                         input logic d, input logic [3:0] fi);
        @(negedge clk);
        if (pending) compare();
        issue = i; op = o; a = va; b = vb; shc = s; sf = f; dpc = d; fl_in = fi;
        model();
        pending = 1;
    endtask

    initial begin
        logic [W-1:0] vals [4];
        vals[0] = 32'h0; vals[1] = 32'h7FFF_FFFF; vals[2] = 32'h8000_0000; vals[3] = 32'hFFFF_FFFF;
        rst_n = 0; issue = 0; op = 0; a = 0; b = 0; shc = 0; sf = 0; dpc = 0; fl_in = 4'hF;
        repeat (3) @(negedge clk);
        chk("R8 reset result", result, 0);
        chk("R8 reset wr_en", wr_en, 0);
        chk("R8 reset flags", fl_out, 0);
        chk("R8 reset restore", restore, 0);
        rst_n = 1;
        for (int o = 0; o < 16; o++)
            for (int ai = 0; ai < 4; ai++)
                for (int bi = 0; bi < 4; bi++)
                    for (int m = 0; m < 4; m++)
                        apply(1'b1, 4'(o), vals[ai], vals[bi], logic'(m[1] ^ ai[0]),
                              logic'(m[0]), 1'b0, m[1] ? 4'b0110 : 4'b1001);
        for (int o = 0; o < 16; o++)
            for (int m = 0; m < 4; m++) begin
                apply(1'b1, 4'(o), 32'h1234_5678, 32'h1234_5678, 1'b1,
                      logic'(m[0]), logic'(m[1]), 4'b1010);
                apply(1'b0, 4'(o), 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 4'(m * 5));
            end
        for (int k = 0; k < 3000; k++)
            apply(($urandom % 10) != 0, 4'($urandom), $urandom, $urandom, 1'($urandom),
                  1'($urandom), ($urandom % 4) == 0, 4'($urandom));
        apply(1'b0, 4'd0, 0, 0, 0, 0, 0, 4'h0);
        @(negedge clk);
        compare();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule